// File: doc/BRIEF.md
# Accumulator Multiply/Divide Unit

This block is a sequential arithmetic engine for multiply and divide on accumulator-style register pairs. A single-cycle start pulse loads an operation code, a size bit, the low accumulator word, the high accumulator word and a source operand. The unit then works through one operand bit per clock. It finishes with a one-cycle completion pulse. The result pair is held on its outputs until the next operation completes.

Signed operations run on operand magnitudes, and a final stage restores the signs. Divide first checks whether the quotient can fit, which also catches a zero divisor. After the last iteration it checks the signed range. Whenever a divide error is raised, the result outputs return the original accumulator values.

Two combinational helpers are always live. One widens the low byte to a word. The other widens the low accumulator word into a doubleword high half.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code encoding: 00 unsigned multiply, 01 signed multiply, 10 unsigned divide, 11 signed divide; `wide`=0 selects byte mode. In byte mode, multiply places the 16-bit product of `acc_lo[7:0]` and `src[7:0]` on `res_lo`, and `res_hi` returns `acc_hi` unchanged.
- R2: With `wide`=1, multiply of `acc_lo` by `src` places the 32-bit product on `{res_hi,res_lo}`, signed or unsigned per the opcode.
- R3: In byte mode, divide of `acc_lo` by `src[7:0]` places the quotient in `res_lo[7:0]` and the remainder in `res_lo[15:8]`, and `res_hi` returns `acc_hi`.
- R4: With `wide`=1, divide of `{acc_hi,acc_lo}` by `src` places the quotient on `res_lo` and the remainder on `res_hi`.
- R5: Signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend.
- R6: A zero divisor raises `div_err` together with `done`, and `res_lo`/`res_hi` then equal the `acc_lo`/`acc_hi` that were given at start.
- R7: A quotient outside the destination range raises `div_err` and leaves the results as in R6. The range is 0..2^n-1 for unsigned divide and -2^(n-1)..2^(n-1)-1 for signed divide, where n is 8 in byte mode and 16 with `wide`. Multiply never raises `div_err`.
- R8: `sext_word` equals `acc_lo[7:0]` with its high byte filled by copies of `acc_lo[7]`, at all times.
- R9: `sext_dword` is all ones when `acc_lo[15]` is 1 and all zeros otherwise, at all times.
- R10: `done` is a one-cycle pulse that is high after the (n+1)-th rising edge following the edge that samples `start`, where n is 8 or 16. `busy` is high from that sampling edge until `done` rises.
- R11: A `start` that is seen while `busy` is high is ignored. The running operation completes with its original operands and timing, and no new operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | Operation code (see R1) |
| wide | input | 1 | 0 byte mode, 1 word mode |
| acc_lo | input | 16 | Low accumulator word |
| acc_hi | input | 16 | High accumulator word |
| src | input | 16 | Source operand |
| res_lo | output | 16 | Result low word |
| res_hi | output | 16 | Result high word |
| done | output | 1 | Completion pulse |
| div_err | output | 1 | Divide error pulse, coincident with done |
| busy | output | 1 | Operation in progress |
| sext_word | output | 16 | Byte-to-word widening of acc_lo |
| sext_dword | output | 16 | High word of acc_lo widened to a doubleword |

## Verification
A new start can coincide with completion. In the cycle where `done` is visible the unit is already idle, so a start sampled there must be accepted. A start sampled one edge earlier, during the final sign-fix cycle, must be dropped. The bench issues every operation back to back, so each new start lands in the `done` cycle of the one before it, and it checks both the result and the exact latency of each operation. A separate case holds `start` high through every cycle of a running operation, including the fix cycle. It then checks that the first result arrives on time with its own operands and that `busy` stays low afterwards.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULU = 2'b00,
        OP_MULS = 2'b01,
        OP_DIVU = 2'b10,
        OP_DIVS = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIX  = 2'b10
    } md_state_e;

endpackage

// File: rtl/muldiv_widen.sv
module muldiv_widen #(
    parameter int BW = 8
) (
    input  logic [2*BW-1:0] acc_lo,
    output logic [2*BW-1:0] sext_word,
    output logic [2*BW-1:0] sext_dword
);
    localparam int W = 2 * BW;

    always_comb begin
        sext_word  = {{BW{acc_lo[BW-1]}}, acc_lo[BW-1:0]};
        sext_dword = {W{acc_lo[W-1]}};
    end
endmodule

// File: rtl/muldiv_operand.sv
module muldiv_operand #(
    parameter int BW = 8
) (
    input  logic              is_signed,
    input  logic              wide,
    input  logic [2*BW-1:0]   acc_lo,
    input  logic [2*BW-1:0]   acc_hi,
    input  logic [2*BW-1:0]   src,
    output logic [2*BW-1:0]   mag_a,
    output logic [2*BW-1:0]   mag_b,
    output logic              neg_a,
    output logic              neg_b,
    output logic              neg_dvd,
    output logic [2*BW-1:0]   dvd_upper,
    output logic [2*BW-1:0]   dvd_lower
);
    localparam int W  = 2 * BW;
    localparam int DW = 2 * W;

    logic [W-1:0]  a_raw;
    logic [W-1:0]  b_raw;
    logic [DW-1:0] dvd_raw;
    logic [DW-1:0] dvd_mag;

    always_comb begin
        if (wide) begin
            a_raw = acc_lo;
            b_raw = src;
        end else if (is_signed) begin
            a_raw = {{BW{acc_lo[BW-1]}}, acc_lo[BW-1:0]};
            b_raw = {{BW{src[BW-1]}}, src[BW-1:0]};
        end else begin
            a_raw = {{BW{1'b0}}, acc_lo[BW-1:0]};
            b_raw = {{BW{1'b0}}, src[BW-1:0]};
        end

        neg_a = is_signed & a_raw[W-1];
        neg_b = is_signed & b_raw[W-1];
        mag_a = neg_a ? (~a_raw + 1'b1) : a_raw;
        mag_b = neg_b ? (~b_raw + 1'b1) : b_raw;

        if (wide)
            dvd_raw = {acc_hi, acc_lo};
        else if (is_signed)
            dvd_raw = {{W{acc_lo[W-1]}}, acc_lo};
        else
            dvd_raw = {{W{1'b0}}, acc_lo};

        neg_dvd = is_signed & dvd_raw[DW-1];
        dvd_mag = neg_dvd ? (~dvd_raw + 1'b1) : dvd_raw;

        if (wide) begin
            dvd_upper = dvd_mag[DW-1:W];
            dvd_lower = dvd_mag[W-1:0];
        end else begin
            dvd_upper = {{BW{1'b0}}, dvd_mag[W-1:BW]};
            dvd_lower = {dvd_mag[BW-1:0], {BW{1'b0}}};
        end
    end
endmodule

// File: rtl/muldiv_fixup.sv
module muldiv_fixup #(
    parameter int BW = 8
) (
    input  logic              is_div,
    input  logic              is_signed,
    input  logic              wide,
    input  logic              neg_x,
    input  logic              neg_y,
    input  logic              pre_err,
    input  logic [4*BW-1:0]   prod,
    input  logic [2*BW-1:0]   quo,
    input  logic [2*BW-1:0]   rem,
    input  logic [2*BW-1:0]   lo_sv,
    input  logic [2*BW-1:0]   hi_sv,
    output logic [2*BW-1:0]   res_lo,
    output logic [2*BW-1:0]   res_hi,
    output logic              err
);
    localparam int W  = 2 * BW;
    localparam int DW = 2 * W;

    logic [DW-1:0] p_fix;
    logic [W-1:0]  q_fix;
    logic [W-1:0]  r_fix;
    logic [W-1:0]  lim;
    logic          q_neg;
    logic          range_bad;

    always_comb begin
        q_neg     = is_signed & (neg_x ^ neg_y);
        p_fix     = q_neg ? (~prod + 1'b1) : prod;
        q_fix     = q_neg ? (~quo + 1'b1) : quo;
        r_fix     = (is_signed & neg_x) ? (~rem + 1'b1) : rem;
        lim       = {{(W-1){1'b0}}, 1'b1} << (wide ? (W - 1) : (BW - 1));
        range_bad = is_signed & (q_neg ? (quo > lim) : (quo >= lim));
        err       = 1'b0;
        res_lo    = lo_sv;
        res_hi    = hi_sv;

        if (!is_div) begin
            res_lo = p_fix[W-1:0];
            res_hi = wide ? p_fix[DW-1:W] : hi_sv;
        end else begin
            err = pre_err | range_bad;
            if (!err) begin
                if (wide) begin
                    res_lo = q_fix;
                    res_hi = r_fix;
                end else begin
                    res_lo = {r_fix[BW-1:0], q_fix[BW-1:0]};
                    res_hi = hi_sv;
                end
            end
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              wide,
    input  logic [2*BW-1:0]   acc_lo,
    input  logic [2*BW-1:0]   acc_hi,
    input  logic [2*BW-1:0]   src,
    output logic [2*BW-1:0]   res_lo,
    output logic [2*BW-1:0]   res_hi,
    output logic              done,
    output logic              div_err,
    output logic              busy,
    output logic [2*BW-1:0]   sext_word,
    output logic [2*BW-1:0]   sext_dword
);
    localparam int W  = 2 * BW;
    localparam int DW = 2 * W;
    localparam int CW = $clog2(W) + 1;

    typedef struct packed {
        md_state_e      st;
        logic [CW-1:0]  cnt;
        md_op_e         op;
        logic           wide;
        logic           neg_x;
        logic           neg_y;
        logic           pre_err;
        logic [W-1:0]   lo_sv;
        logic [W-1:0]   hi_sv;
        logic [DW-1:0]  prod;
        logic [DW-1:0]  mcand;
        logic [W-1:0]   mplier;
        logic [W-1:0]   rem;
        logic [W-1:0]   dlo;
        logic [W-1:0]   quo;
        logic [W-1:0]   dvs;
        logic [W-1:0]   res_lo;
        logic [W-1:0]   res_hi;
        logic           done;
        logic           err;
    } md_ctx_t;

    md_ctx_t ctx_d, ctx_q;

    logic [W-1:0] mag_a, mag_b, dvd_upper, dvd_lower;
    logic         neg_a, neg_b, neg_dvd;
    logic [W-1:0] fx_lo, fx_hi;
    logic         fx_err;
    logic [W:0]   trial;

    muldiv_widen #(.BW(BW)) u_widen (
        .acc_lo     (acc_lo),
        .sext_word  (sext_word),
        .sext_dword (sext_dword)
    );

    muldiv_operand #(.BW(BW)) u_operand (
        .is_signed (op[0]),
        .wide      (wide),
        .acc_lo    (acc_lo),
        .acc_hi    (acc_hi),
        .src       (src),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg_a     (neg_a),
        .neg_b     (neg_b),
        .neg_dvd   (neg_dvd),
        .dvd_upper (dvd_upper),
        .dvd_lower (dvd_lower)
    );

    muldiv_fixup #(.BW(BW)) u_fixup (
        .is_div    (ctx_q.op[1]),
        .is_signed (ctx_q.op[0]),
        .wide      (ctx_q.wide),
        .neg_x     (ctx_q.neg_x),
        .neg_y     (ctx_q.neg_y),
        .pre_err   (ctx_q.pre_err),
        .prod      (ctx_q.prod),
        .quo       (ctx_q.quo),
        .rem       (ctx_q.rem),
        .lo_sv     (ctx_q.lo_sv),
        .hi_sv     (ctx_q.hi_sv),
        .res_lo    (fx_lo),
        .res_hi    (fx_hi),
        .err       (fx_err)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        ctx_d.err  = 1'b0;
        trial      = {ctx_q.rem, ctx_q.dlo[W-1]};

        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.st      = ST_RUN;
                    ctx_d.cnt     = wide ? CW'(W - 1) : CW'(BW - 1);
                    ctx_d.op      = md_op_e'(op);
                    ctx_d.wide    = wide;
                    ctx_d.lo_sv   = acc_lo;
                    ctx_d.hi_sv   = acc_hi;
                    ctx_d.prod    = '0;
                    ctx_d.mcand   = {{W{1'b0}}, mag_a};
                    ctx_d.mplier  = mag_b;
                    ctx_d.rem     = dvd_upper;
                    ctx_d.dlo     = dvd_lower;
                    ctx_d.quo     = '0;
                    ctx_d.dvs     = mag_b;
                    ctx_d.pre_err = (dvd_upper >= mag_b);
                    ctx_d.neg_x   = op[1] ? neg_dvd : neg_a;
                    ctx_d.neg_y   = neg_b;
                end
            end
            ST_RUN: begin
                if (ctx_q.op[1]) begin
                    if (trial >= {1'b0, ctx_q.dvs}) begin
                        ctx_d.rem = trial[W-1:0] - ctx_q.dvs;
                        ctx_d.quo = {ctx_q.quo[W-2:0], 1'b1};
                    end else begin
                        ctx_d.rem = trial[W-1:0];
                        ctx_d.quo = {ctx_q.quo[W-2:0], 1'b0};
                    end
                    ctx_d.dlo = ctx_q.dlo << 1;
                end else begin
                    if (ctx_q.mplier[0])
                        ctx_d.prod = ctx_q.prod + ctx_q.mcand;
                    ctx_d.mcand  = ctx_q.mcand << 1;
                    ctx_d.mplier = ctx_q.mplier >> 1;
                end
                ctx_d.cnt = ctx_q.cnt - 1'b1;
                if (ctx_q.cnt == '0)
                    ctx_d.st = ST_FIX;
            end
            ST_FIX: begin
                ctx_d.st     = ST_IDLE;
                ctx_d.done   = 1'b1;
                ctx_d.err    = fx_err;
                ctx_d.res_lo = fx_lo;
                ctx_d.res_hi = fx_hi;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctx_q <= '0;
        else
            ctx_q <= ctx_d;
    end

    assign res_lo  = ctx_q.res_lo;
    assign res_hi  = ctx_q.res_hi;
    assign done    = ctx_q.done;
    assign div_err = ctx_q.err;
    assign busy    = (ctx_q.st != ST_IDLE);

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy ends exactly when done appears
    a_r10_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: the final iteration hands over to the fix cycle
    a_r10_last_iter: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_RUN && ctx_q.cnt == '0) |=> (ctx_q.st == ST_FIX));

    // R6/R7: an error returns the accumulators captured at start
    a_r6_err_restores: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (done && res_lo == ctx_q.lo_sv && res_hi == ctx_q.hi_sv));

    // R7: multiply never signals a divide error
    a_r7_mul_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ctx_q.op[1]) |-> !div_err);

    // R11: a start while running leaves the captured operation alone
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(ctx_q.op) && $stable(ctx_q.lo_sv) && $stable(ctx_q.wide)));

    // R9: the doubleword helper is a pure fill
    a_r9_dword_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (sext_dword == '0) || (sext_dword == '1));

endmodule

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        wide = 1'b0;
    logic [15:0] acc_lo = '0, acc_hi = '0, src = '0;
    logic [15:0] res_lo, res_hi, sext_word, sext_dword;
    logic        done, div_err, busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    muldiv_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .src(src),
        .res_lo(res_lo), .res_hi(res_hi), .done(done), .div_err(div_err),
        .busy(busy), .sext_word(sext_word), .sext_dword(sext_dword)
    );

    task automatic chk(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] o, input logic w,
                                  input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] s,
                                  output logic [15:0] elo, output logic [15:0] ehi,
                                  output logic eerr, output string tag);
        longint a, b, p, dvd, dvs, q, r, n;
        logic sg;
        sg = o[0];
        eerr = 1'b0;
        elo = lo;
        ehi = hi;
        if (w) b = sg ? longint'($signed(s)) : longint'({1'b0, s});
        else   b = sg ? longint'($signed(s[7:0])) : longint'({1'b0, s[7:0]});
        n = w ? 16 : 8;
        if (!o[1]) begin
            if (w) a = sg ? longint'($signed(lo)) : longint'({1'b0, lo});
            else   a = sg ? longint'($signed(lo[7:0])) : longint'({1'b0, lo[7:0]});
            p = a * b;
            elo = p[15:0];
            if (w) ehi = p[31:16];
            tag = w ? "R2" : "R1";
        end else begin
            if (w) dvd = sg ? longint'($signed({hi, lo})) : longint'({1'b0, hi, lo});
            else   dvd = sg ? longint'($signed(lo)) : longint'({1'b0, lo});
            dvs = b;
            if (dvs == 0) begin
                eerr = 1'b1;
                tag = "R6";
            end else begin
                q = dvd / dvs;
                r = dvd % dvs;
                if (sg) eerr = (q > (longint'(1) << (n - 1)) - 1) || (q < -(longint'(1) << (n - 1)));
                else    eerr = (q > (longint'(1) << n) - 1);
                if (eerr) tag = "R7";
                else if (sg && (dvd < 0 || dvs < 0)) tag = "R5";
                else tag = w ? "R4" : "R3";
                if (!eerr) begin
                    if (w) begin
                        elo = q[15:0];
                        ehi = r[15:0];
                    end else begin
                        elo = {r[7:0], q[7:0]};
                    end
                end
            end
        end
    endfunction

    // Issues one operation; inputs change at a falling edge.
    task automatic run_op(input logic [1:0] o, input logic w,
                          input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] s);
        logic [15:0] elo, ehi;
        logic eerr;
        string tag;
        int cyc;
        op = o; wide = w; acc_lo = lo; acc_hi = hi; src = s; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        model(o, w, lo, hi, s, elo, ehi, eerr, tag);
        chk(tag, {div_err, res_hi, res_lo} === {eerr, ehi, elo},
            {31'd0, div_err, res_hi, res_lo}, {31'd0, eerr, ehi, elo});
        chk("R10", cyc == (w ? 17 : 9), 64'(cyc), 64'(w ? 17 : 9));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] wl [12];
        logic [15:0] hl [6];
        logic [15:0] ll [6];
        wl = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0007, 16'h007F,
               16'h0080, 16'h00FF, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        hl = '{16'h0000, 16'h0001, 16'h007F, 16'h8000, 16'hFFFF, 16'hFFFE};
        ll = '{16'h0000, 16'h8000, 16'hFFFF, 16'h0001, 16'h7FFF, 16'hABCD};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset", {done, div_err, busy} == 3'b000, {61'd0, done, div_err, busy}, 64'd0);
        chk("R1 reset", {res_hi, res_lo} == 32'd0, {32'd0, res_hi, res_lo}, 64'd0);

        // R8 / R9: helpers over a stride of accumulator values
        for (int v = 0; v < 65536; v += 127) begin
            acc_lo = 16'(v);
            #1;
            chk("R8", sext_word == {{8{acc_lo[7]}}, acc_lo[7:0]}, 64'(sext_word), 64'({{8{acc_lo[7]}}, acc_lo[7:0]}));
            chk("R9", sext_dword == {16{acc_lo[15]}}, 64'(sext_dword), 64'({16{acc_lo[15]}}));
        end
        @(negedge clk);

        // R1: byte multiply, unsigned and signed
        for (int a = 0; a < 256; a += 9)
            for (int b = 0; b < 256; b += 11) begin
                run_op(2'b00, 1'b0, 16'(a) | 16'hA500, 16'h5A5A, 16'(b) | 16'h3300);
                run_op(2'b01, 1'b0, 16'(a), 16'hC3C3, 16'(b));
            end
        run_op(2'b01, 1'b0, 16'h0080, 16'h1111, 16'h0080);
        run_op(2'b01, 1'b0, 16'h007F, 16'h1111, 16'h0080);

        // R2: word multiply corners
        foreach (wl[i])
            foreach (wl[j]) begin
                run_op(2'b00, 1'b1, wl[i], 16'hDEAD, wl[j]);
                run_op(2'b01, 1'b1, wl[i], 16'hBEEF, wl[j]);
            end

        // R3 / R5 / R6 / R7: byte divide sweep
        for (int d = 0; d < 65536; d += 997)
            for (int s = 0; s < 256; s += 5) begin
                run_op(2'b10, 1'b0, 16'(d), 16'h6C6C, 16'(s));
                run_op(2'b11, 1'b0, 16'(d), 16'h9393, 16'(s));
            end
        run_op(2'b11, 1'b0, 16'h8000, 16'h0102, 16'h00FF);
        run_op(2'b11, 1'b0, 16'hFF80, 16'h0102, 16'h00FF);
        run_op(2'b11, 1'b0, 16'hFFF9, 16'h0102, 16'h0002);

        // R4 / R5 / R6 / R7: word divide corners
        foreach (hl[i])
            foreach (ll[j])
                foreach (wl[k]) begin
                    run_op(2'b10, 1'b1, ll[j], hl[i], wl[k]);
                    run_op(2'b11, 1'b1, ll[j], hl[i], wl[k]);
                end
        run_op(2'b11, 1'b1, 16'h0000, 16'h8000, 16'hFFFF);
        run_op(2'b11, 1'b1, 16'h8000, 16'hFFFF, 16'hFFFF);

        // R11: start held high through a whole byte divide, including the fix cycle
        begin
            int cyc;
            op = 2'b10; wide = 1'b0; acc_lo = 16'd1000; acc_hi = 16'h7777; src = 16'd7; start = 1'b1;
            @(posedge clk);
            @(negedge clk);
            op = 2'b00; wide = 1'b1; acc_lo = 16'hFFFF; acc_hi = 16'h0000; src = 16'hFFFF;
            cyc = 0;
            while (!done && cyc < 40) begin
                @(posedge clk);
                cyc++;
                @(negedge clk);
            end
            start = 1'b0;
            chk("R11 result", {div_err, res_hi, res_lo} == {1'b0, 16'h7777, 8'd6, 8'd142},
                {31'd0, div_err, res_hi, res_lo}, {31'd0, 1'b0, 16'h7777, 8'd6, 8'd142});
            chk("R11 latency", cyc == 9, 64'(cyc), 64'd9);
            @(posedge clk);
            @(negedge clk);
            chk("R11 no restart", busy == 1'b0, 64'(busy), 64'd0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule